// File: doc/BRIEF.md
# Memory Version Tag Checker

The block guards a small modelled memory region of 256 lines, each 64 bytes wide. It keeps one 4-bit version tag per line. Software sets a tag with a tag-write command. A block-initialise command returns a line's tag to zero. Every load and store arrives with a pointer whose top four bits carry the version the access expects. The block compares that version with the tag stored for the addressed line and reports the outcome one cycle later.

Checking applies only while the global enable input is high and the enable bit of the addressed page is set. A page covers 16 lines. Two tag values act as wildcards. A mismatch on a load always gives a precise trap. For a store, the precise-mode input chooses between two outcomes: a precise trap, or a deferred trap that records the program counter in a sticky slot until software clears it. Tag writes are refused while checking is globally off, and also when the page is read-only. Address translation and the delivery of traps to software lie outside the block. Only address bits 13:0 and 63:60 select anything.

Top module: `line_tag_guard`

## Requirements
- R1: After reset, every stored tag is 0, the deferred-pending flag is low, no response is valid, and the request port is ready.
- R2: Each accepted request (valid and ready high at a clock edge) yields exactly one response, valid on the following cycle. No response is valid in a cycle that follows an edge with no accepted request.
- R3: The expected tag is address bits 63:60 and the line is address bits 13:6. A load (op 0) whose tags mismatch returns kind PRECISE (1) with code 0x1A and the request address in the response.
- R4: No access traps unless the global enable input is high and the page-enable bit indexed by address bits 13:10 is high.
- R5: A value of 0x0 or 0xF on either side (the address tag or the stored tag) matches anything.
- R6: A mismatching store (op 1) with precise mode high returns PRECISE with code 0x1A.
- R7: A mismatching store with precise mode low returns kind DEFER (2) with code 0. It sets the pending flag and records that store's PC.
- R8: While the pending flag is set, later deferred stores leave the recorded PC unchanged. A clear pulse drops the flag, after which the next deferred store records a new PC.
- R9: A non-faulting load (op 2) never traps.
- R10: A tag write (op 3) while the global enable is low returns kind TAGDIS (3) with code 0x0A and leaves the tag unchanged.
- R11: A tag write to a page whose writable bit is low returns kind REJECT (4) and leaves the tag unchanged. Otherwise, with the global enable high, the tag write stores the request's write tag and returns kind NONE (0).
- R12: A block-initialise (op 4) sets the line's tag to 0 and returns NONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global checking enable |
| prec_mode | input | 1 | Store mismatches give a precise trap when high |
| pg_chk_en | input | 16 | Per-page checking enable |
| pg_wr_en | input | 16 | Per-page writable bit |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_op | input | 3 | 0 load, 1 store, 2 non-faulting load, 3 tag write, 4 block-initialise |
| req_addr | input | 64 | Tagged address |
| req_pc | input | 64 | PC of the requesting instruction |
| req_wtag | input | 4 | Tag value for a tag write |
| pend_clr | input | 1 | Clears the deferred-pending flag |
| rsp_valid | output | 1 | Response valid |
| rsp_kind | output | 3 | 0 NONE, 1 PRECISE, 2 DEFER, 3 TAGDIS, 4 REJECT |
| rsp_code | output | 8 | Trap type code (0x1A, 0x0A or 0) |
| rsp_addr | output | 64 | Address of the request answered |
| dfr_pend | output | 1 | Sticky deferred-trap pending flag |
| dfr_pc | output | 64 | PC of the first deferred store mismatch |

## Verification
The assertions assume that req_op only carries the five defined codes and that the page-attribute inputs stay steady while a request is in flight. The stimulus keeps to both. Every operation is one of the five, and the enables and page bits change only in idle cycles between requests. The assertions also assume that pend_clr is a single-cycle pulse, and the bench drives it only as one.

// File: rtl/ltg_pkg.sv
package ltg_pkg;

    localparam int TAG_W = 4;
    localparam logic [7:0] CODE_PRECISE = 8'h1A;
    localparam logic [7:0] CODE_TAGDIS  = 8'h0A;

    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_STORE   = 3'd1,
        OP_NFLOAD  = 3'd2,
        OP_TAGWR   = 3'd3,
        OP_BLKINIT = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        TRAP_NONE    = 3'd0,
        TRAP_PRECISE = 3'd1,
        TRAP_DEFER   = 3'd2,
        TRAP_TAGDIS  = 3'd3,
        TRAP_REJECT  = 3'd4
    } trap_e;

    typedef struct packed {
        trap_e      kind;
        logic [7:0] code;
    } verdict_t;

    function automatic logic is_wild(input logic [TAG_W-1:0] t);
        return (t == '0) || (t == '1);
    endfunction

endpackage

// File: rtl/ltg_tag_store.sv
module ltg_tag_store import ltg_pkg::*; #(
    parameter int NUM_LINES = 256,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_data
);

    logic [TAG_W-1:0] mem [NUM_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LINES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_tag = mem[rd_idx];

    // R11
    wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/ltg_tag_match.sv
module ltg_tag_match import ltg_pkg::*; (
    input  logic             chk_on,
    input  logic [TAG_W-1:0] addr_tag,
    input  logic [TAG_W-1:0] line_tag,
    output logic             mismatch
);

    always_comb begin
        mismatch = 1'b0;
        if (chk_on && !is_wild(addr_tag) && !is_wild(line_tag))
            mismatch = (addr_tag != line_tag);
    end

    // R5
    wild_store_chk: assert final ((line_tag != 4'hF) || !mismatch);

endmodule

// File: rtl/ltg_defer_rec.sv
module ltg_defer_rec #(
    parameter int PC_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set,
    input  logic [PC_W-1:0] set_pc,
    input  logic            clr,
    output logic            pend,
    output logic [PC_W-1:0] pc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            pc   <= '0;
        end else if (set && (clr || !pend)) begin
            pend <= 1'b1;
            pc   <= set_pc;
        end else if (clr) begin
            pend <= 1'b0;
        end
    end

    // R8
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> (pend && $stable(pc)));

endmodule

// File: rtl/line_tag_guard.sv
module line_tag_guard import ltg_pkg::*; #(
    parameter int ADDR_W     = 64,
    parameter int LINE_BYTES = 64,
    parameter int NUM_LINES  = 256,
    parameter int PAGE_BYTES = 1024,
    localparam int NUM_PAGES = NUM_LINES * LINE_BYTES / PAGE_BYTES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 glb_en,
    input  logic                 prec_mode,
    input  logic [NUM_PAGES-1:0] pg_chk_en,
    input  logic [NUM_PAGES-1:0] pg_wr_en,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [2:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [ADDR_W-1:0]    req_pc,
    input  logic [3:0]           req_wtag,
    input  logic                 pend_clr,
    output logic                 rsp_valid,
    output logic [2:0]           rsp_kind,
    output logic [7:0]           rsp_code,
    output logic [ADDR_W-1:0]    rsp_addr,
    output logic                 dfr_pend,
    output logic [ADDR_W-1:0]    dfr_pc
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int PG_OFF = $clog2(PAGE_BYTES);
    localparam int PG_W   = $clog2(NUM_PAGES);
    localparam int REG_HI = OFF_W + IDX_W;

    logic             acc;
    op_e              op;
    logic [TAG_W-1:0] atag, stag, wr_data;
    logic [IDX_W-1:0] idx;
    logic [PG_W-1:0]  pg;
    logic             chk_on, mism, wr_en, set_dfr;
    verdict_t         vd;
    logic             unused_addr_bits;

    assign req_ready = !rst;
    assign acc       = req_valid && req_ready;
    assign op        = op_e'(req_op);
    assign atag      = req_addr[ADDR_W-1 -: TAG_W];
    assign idx       = req_addr[OFF_W +: IDX_W];
    assign pg        = req_addr[PG_OFF +: PG_W];
    assign chk_on    = glb_en && pg_chk_en[pg];
    assign unused_addr_bits = ^{req_addr[ADDR_W-TAG_W-1:REG_HI], req_addr[OFF_W-1:0]};

    ltg_tag_store #(.NUM_LINES(NUM_LINES)) u_store (
        .clk(clk), .rst(rst), .rd_idx(idx), .rd_tag(stag),
        .wr_en(wr_en), .wr_idx(idx), .wr_data(wr_data)
    );

    ltg_tag_match u_match (
        .chk_on(chk_on), .addr_tag(atag), .line_tag(stag), .mismatch(mism)
    );

    always_comb begin
        vd      = '{kind: TRAP_NONE, code: 8'h00};
        wr_en   = 1'b0;
        wr_data = '0;
        set_dfr = 1'b0;
        case (op)
            OP_LOAD: if (mism) vd = '{kind: TRAP_PRECISE, code: CODE_PRECISE};
            OP_STORE: begin
                if (mism && prec_mode) begin
                    vd = '{kind: TRAP_PRECISE, code: CODE_PRECISE};
                end else if (mism) begin
                    vd      = '{kind: TRAP_DEFER, code: 8'h00};
                    set_dfr = acc;
                end
            end
            OP_TAGWR: begin
                if (!glb_en) begin
                    vd = '{kind: TRAP_TAGDIS, code: CODE_TAGDIS};
                end else if (!pg_wr_en[pg]) begin
                    vd = '{kind: TRAP_REJECT, code: 8'h00};
                end else begin
                    wr_en   = acc;
                    wr_data = req_wtag;
                end
            end
            OP_BLKINIT: wr_en = acc;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= TRAP_NONE;
            rsp_code  <= '0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= acc;
            if (acc) begin
                rsp_kind <= vd.kind;
                rsp_code <= vd.code;
                rsp_addr <= req_addr;
            end
        end
    end

    ltg_defer_rec #(.PC_W(ADDR_W)) u_defer (
        .clk(clk), .rst(rst), .set(set_dfr), .set_pc(req_pc),
        .clr(pend_clr), .pend(dfr_pend), .pc(dfr_pc)
    );

    // R2
    one_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid);
    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !rsp_valid);
    // R9
    nf_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op == 3'd2) |=> (rsp_kind == 3'd0));
    // R10
    tagdis_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op == 3'd3 && !glb_en) |=> (rsp_kind == 3'd3 && rsp_code == 8'h0A));
    // R4
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !glb_en && req_op != 3'd3) |=> (rsp_kind == 3'd0));

endmodule

// File: tb/line_tag_guard_tb.sv
module line_tag_guard_tb;
    logic clk = 1'b0, rst = 1'b1;
    logic glb_en = 1'b1, prec_mode = 1'b1, req_valid = 1'b0, pend_clr = 1'b0;
    logic [15:0] pg_chk_en = '1, pg_wr_en = '1;
    logic req_ready, rsp_valid, dfr_pend;
    logic [2:0] req_op = '0, rsp_kind;
    logic [63:0] req_addr = '0, req_pc = '0, rsp_addr, dfr_pc;
    logic [3:0] req_wtag = '0;
    logic [7:0] rsp_code;
    int tests = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    line_tag_guard u_dut (
        .clk(clk), .rst(rst), .glb_en(glb_en), .prec_mode(prec_mode),
        .pg_chk_en(pg_chk_en), .pg_wr_en(pg_wr_en), .req_valid(req_valid),
        .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
        .req_pc(req_pc), .req_wtag(req_wtag), .pend_clr(pend_clr),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_code(rsp_code),
        .rsp_addr(rsp_addr), .dfr_pend(dfr_pend), .dfr_pc(dfr_pc)
    );

    function automatic logic [63:0] mk(input logic [3:0] t, input logic [7:0] line);
        return {t, 46'd0, line, 6'd5};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive one request, return after the response is visible
    task automatic go(input logic [2:0] op, input logic [63:0] a,
                      input logic [63:0] pc, input logic [3:0] wt);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_pc = pc; req_wtag = wt;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic [2:0] kind, input logic [7:0] code);
        chk({req, " valid"}, 64'(rsp_valid), 64'd1);
        chk({req, " kind"}, 64'(rsp_kind), 64'(kind));
        chk({req, " code"}, 64'(rsp_code), 64'(code));
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 ready", 64'(req_ready), 64'd1);
        chk("R1 pend", 64'(dfr_pend), 64'd0);
        go(3'd0, mk(4'h5, 8'd3), 0, 0);
        expect_rsp("R1 zero tag", 3'd0, 8'h00);
        @(negedge clk);
        chk("R2 idle no rsp", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_load;
        go(3'd3, mk(4'h0, 8'd10), 0, 4'hA);
        expect_rsp("R11 tag write ok", 3'd0, 8'h00);
        go(3'd0, mk(4'hA, 8'd10), 0, 0);
        expect_rsp("R3 load match", 3'd0, 8'h00);
        go(3'd0, mk(4'h3, 8'd10), 0, 0);
        expect_rsp("R3 load mismatch", 3'd1, 8'h1A);
        chk("R3 addr", rsp_addr, mk(4'h3, 8'd10));
    endtask

    task automatic t_enables;
        glb_en = 1'b0;
        go(3'd0, mk(4'h3, 8'd10), 0, 0);
        expect_rsp("R4 global off", 3'd0, 8'h00);
        glb_en = 1'b1; pg_chk_en[0] = 1'b0;
        go(3'd1, mk(4'h3, 8'd10), 0, 0);
        expect_rsp("R4 page off", 3'd0, 8'h00);
        pg_chk_en[0] = 1'b1;
    endtask

    task automatic t_wild;
        go(3'd0, mk(4'h0, 8'd10), 0, 0);
        expect_rsp("R5 addr 0", 3'd0, 8'h00);
        go(3'd0, mk(4'hF, 8'd10), 0, 0);
        expect_rsp("R5 addr F", 3'd0, 8'h00);
        go(3'd3, mk(4'h0, 8'd20), 0, 4'hF);
        go(3'd0, mk(4'h7, 8'd20), 0, 0);
        expect_rsp("R5 stored F", 3'd0, 8'h00);
    endtask

    task automatic t_store;
        prec_mode = 1'b1;
        go(3'd1, mk(4'h3, 8'd10), 64'h900, 0);
        expect_rsp("R6 precise store", 3'd1, 8'h1A);
        chk("R6 no pend", 64'(dfr_pend), 64'd0);
        prec_mode = 1'b0;
        go(3'd1, mk(4'h3, 8'd10), 64'h1000, 0);
        expect_rsp("R7 defer store", 3'd2, 8'h00);
        chk("R7 pend", 64'(dfr_pend), 64'd1);
        chk("R7 pc", dfr_pc, 64'h1000);
        go(3'd1, mk(4'h4, 8'd10), 64'h2000, 0);
        expect_rsp("R8 second defer", 3'd2, 8'h00);
        chk("R8 pc kept", dfr_pc, 64'h1000);
        @(negedge clk); pend_clr = 1'b1;
        @(negedge clk); pend_clr = 1'b0;
        chk("R8 cleared", 64'(dfr_pend), 64'd0);
        go(3'd1, mk(4'h3, 8'd10), 64'h3000, 0);
        chk("R8 new pc", dfr_pc, 64'h3000);
        @(negedge clk); pend_clr = 1'b1;
        @(negedge clk); pend_clr = 1'b0;
        prec_mode = 1'b1;
    endtask

    task automatic t_nf;
        go(3'd2, mk(4'h3, 8'd10), 0, 0);
        expect_rsp("R9 nf load", 3'd0, 8'h00);
    endtask

    task automatic t_tagdis;
        glb_en = 1'b0;
        go(3'd3, mk(4'h0, 8'd10), 0, 4'h5);
        expect_rsp("R10 tag write off", 3'd3, 8'h0A);
        glb_en = 1'b1;
        go(3'd0, mk(4'hA, 8'd10), 0, 0);
        expect_rsp("R10 tag kept", 3'd0, 8'h00);
        go(3'd0, mk(4'h5, 8'd10), 0, 0);
        expect_rsp("R10 not written", 3'd1, 8'h1A);
    endtask

    task automatic t_ro;
        pg_wr_en[1] = 1'b0;
        go(3'd3, mk(4'h0, 8'd17), 0, 4'h6);
        expect_rsp("R11 read-only", 3'd4, 8'h00);
        pg_wr_en[1] = 1'b1;
        go(3'd0, mk(4'h2, 8'd17), 0, 0);
        expect_rsp("R11 tag unchanged", 3'd0, 8'h00);
    endtask

    task automatic t_blkinit;
        go(3'd4, mk(4'h0, 8'd10), 0, 0);
        expect_rsp("R12 blkinit", 3'd0, 8'h00);
        go(3'd0, mk(4'h3, 8'd10), 0, 0);
        expect_rsp("R12 tag cleared", 3'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset; t_load; t_enables; t_wild; t_store;
        t_nf; t_tagdis; t_ro; t_blkinit;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule